// File: doc/BRIEF.md
# Paged Register File for a Legacy Ethernet Controller

This block holds the byte-wide control and status registers of an older-style Ethernet controller. A host reaches it through a 5-bit port address with separate read and write strobes. Offset 0 always reaches the command register. The two top bits of that register choose which page the offsets 1 to 15 decode into. On the first page, reads and writes to the same offset reach different registers. The other pages give access to the station address, the multicast mask and read-back copies of the configuration registers.

Commands written to offset 0 can acknowledge the reset flag, request a remote transfer and start a transmission. An interrupt status byte collects events and is cleared by writing ones to it. A mask register selects which events drive the level interrupt output. Packet storage, the transfer engine and the line side sit outside this block. For transmit, it only emits a start pulse, exposes the frame page and length, and logs a successful completion at once.

Top module: `nic_regfile`

## Requirements
- R1: After reset the command register reads 0x22, interrupt status reads 0x80, the interrupt mask is 0x00, and all eight multicast mask bytes read 0xFF.
- R2: Offset 0 reads and writes the command register whatever page is selected. Command bits [7:6] select the page (0, 1, 2) for offsets 1 to 15. Page 3 decodes nothing.
- R3: On page 0, offset 1 writes the ring start page but reads the local transfer address low byte, and offset 2 reads its high byte. Offset 4 writes the transmit start page but reads the transmit status. The local transfer address is written on page 2 at offsets 1 (low) and 2 (high).
- R4: A page-0 write to offset 7 clears each interrupt status bit whose position is set in bits [6:0] of the written value. Bit 7 is not touched by such a write.
- R5: `irqOut` is high exactly when (status AND mask AND 0x7F) is non-zero. It follows a mask or status change in the same cycle in which the register updates. The mask is written at page 0 offset 15 and read at page 2 offset 15.
- R6: A command write with bit 0 low clears status bit 7. A command write with bit 0 high leaves it unchanged.
- R7: A command write with bit 0 low and bit 3 or bit 4 high sets status bit 6 only if the 16-bit remote byte count is zero. The count is written at page 0 offsets 10 (low) and 11 (high).
- R8: A command write with bit 0 low and bit 2 high gives a one-cycle `txStart` pulse in the cycle after the write. It also sets the transmit status to 0x01 and sets status bit 1, and command bit 2 reads back as 0. With bit 0 high, no pulse occurs and the command is stored as written.
- R9: On page 1, offsets 1 to 6 hold station address bytes 0 to 5, offset 7 holds the current page, and offsets 8 to 15 hold multicast bytes 0 to 7. All of them can be written and read back.
- R10: 16-bit registers take their low byte at one offset and their high byte at the next. The remote start address is written at page 0 offsets 8/9 and read at the same offsets. The transmit length is written at page 0 offsets 5/6 and is visible on `txLen`. The transmit page appears on `txPage`.
- R11: Reads of undecoded locations return 0x00 and writes to them change nothing. This covers page 3, port addresses 16 to 31, and the read-only or write-only gaps of pages 0 to 2.
- R12: Page 2 reads back the ring start page (offset 1), ring stop page (2), transmit page (4), receive configuration (12), transmit configuration (13) and data configuration (14). These are written on page 0 at offsets 1, 2, 4, 12, 13 and 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Port address |
| busWrEn | input | 1 | Write strobe, one byte per cycle |
| busRdEn | input | 1 | Read qualifier; read data is combinational |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr` at the current page |
| irqOut | output | 1 | Level interrupt |
| txStart | output | 1 | One-cycle transmit start pulse |
| txPage | output | 8 | Transmit start page |
| txLen | output | 16 | Transmit byte count |

## Verification
A decode slip shows up as a wrong byte on the first read of the affected location, and a stale page shows up on every offset above 0. Most mistakes therefore appear at the very next read. Errors in the status bits are more dangerous: a wrong set or clear changes `irqOut` in the same cycle as the update. A status bit that stays set by mistake keeps the interrupt stuck high until software writes a one to it, so the bench checks `irqOut` right after each status-changing write. A wrong transmit path shows up within one cycle as a missing or doubled `txStart` pulse, or as command bit 2 still set.

// File: rtl/nic_regfile_pkg.sv
`timescale 1ns/1ps
package nic_regfile_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 3;

  // status bit positions
  localparam int ST_RESET_DONE = 7;
  localparam int ST_RDMA_DONE  = 6;
  localparam int ST_TX_OK      = 1;

  // command bit positions
  localparam int CM_STOP  = 0;
  localparam int CM_TX    = 2;
  localparam int CM_RREAD = 3;
  localparam int CM_RWRIT = 4;

  typedef enum logic [1:0] {PG_ZERO, PG_ONE, PG_TWO, PG_NONE} page_e;

  typedef struct packed {
    logic wrStart;
    logic wrStop;
    logic wrBound;
    logic wrTxPage;
    logic wrTxLenLo;
    logic wrTxLenHi;
    logic clrStatus;
    logic wrRsarLo;
    logic wrRsarHi;
    logic wrRcntLo;
    logic wrRcntHi;
    logic wrRxCfg;
    logic wrTxCfg;
    logic wrDataCfg;
    logic wrMask;
    logic wrStation;
    logic wrCurPage;
    logic wrMcast;
    logic wrLdmaLo;
    logic wrLdmaHi;
    logic wrRnext;
    logic wrLnext;
    logic wrAcntLo;
    logic wrAcntHi;
    logic clrResetFlag;
    logic setRdmaDone;
    logic setTxDone;
    logic [IDX_W-1:0] byteIdx;
  } strobe_t;
endpackage

// File: rtl/nic_regfile_ctrl.sv
`timescale 1ns/1ps
module nic_regfile_ctrl
  import nic_regfile_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int STATION_BYTES = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              rcntZero,
  output logic [DATA_W-1:0] cmdQ,
  output page_e             pageSel,
  output strobe_t           strb,
  output logic              txStart
);
  localparam int OFF_W = 4;
  localparam logic [DATA_W-1:0] CMD_RESET = DATA_W'(8'h22);
  localparam logic [OFF_W-1:0] LAST_STATION = OFF_W'(STATION_BYTES);

  logic [OFF_W-1:0] off;
  logic inWindow;
  logic cmdWrite;
  logic regWrite;

  assign off      = busAddr[OFF_W-1:0];
  assign inWindow = (busAddr[ADDR_W-1:OFF_W] == '0);
  assign cmdWrite = busWrEn && inWindow && (off == '0);
  assign regWrite = busWrEn && inWindow && (off != '0);
  assign pageSel  = page_e'(cmdQ[DATA_W-1:DATA_W-2]);

  always_comb begin
    strb = '0;
    strb.clrResetFlag = cmdWrite && !busWdata[CM_STOP];
    strb.setRdmaDone  = strb.clrResetFlag &&
                        (busWdata[CM_RREAD] || busWdata[CM_RWRIT]) && rcntZero;
    strb.setTxDone    = strb.clrResetFlag && busWdata[CM_TX];
    if (regWrite) begin
      unique case (pageSel)
        PG_ZERO: begin
          unique case (off)
            4'h1: strb.wrStart   = 1'b1;
            4'h2: strb.wrStop    = 1'b1;
            4'h3: strb.wrBound   = 1'b1;
            4'h4: strb.wrTxPage  = 1'b1;
            4'h5: strb.wrTxLenLo = 1'b1;
            4'h6: strb.wrTxLenHi = 1'b1;
            4'h7: strb.clrStatus = 1'b1;
            4'h8: strb.wrRsarLo  = 1'b1;
            4'h9: strb.wrRsarHi  = 1'b1;
            4'hA: strb.wrRcntLo  = 1'b1;
            4'hB: strb.wrRcntHi  = 1'b1;
            4'hC: strb.wrRxCfg   = 1'b1;
            4'hD: strb.wrTxCfg   = 1'b1;
            4'hE: strb.wrDataCfg = 1'b1;
            4'hF: strb.wrMask    = 1'b1;
            default: ;
          endcase
        end
        PG_ONE: begin
          if (off <= LAST_STATION) begin
            strb.wrStation = 1'b1;
            strb.byteIdx   = IDX_W'(off - 4'd1);
          end else if (off == 4'h7) begin
            strb.wrCurPage = 1'b1;
          end else begin
            strb.wrMcast = 1'b1;
            strb.byteIdx = off[IDX_W-1:0];
          end
        end
        PG_TWO: begin
          unique case (off)
            4'h1: strb.wrLdmaLo = 1'b1;
            4'h2: strb.wrLdmaHi = 1'b1;
            4'h3: strb.wrRnext  = 1'b1;
            4'h5: strb.wrLnext  = 1'b1;
            4'h6: strb.wrAcntLo = 1'b1;
            4'h7: strb.wrAcntHi = 1'b1;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ    <= CMD_RESET;
      txStart <= 1'b0;
    end else begin
      txStart <= strb.setTxDone;
      if (cmdWrite) begin
        cmdQ <= busWdata;
        if (strb.setTxDone) cmdQ[CM_TX] <= 1'b0;
      end
    end
  end

  AST_TX_CMD_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> !cmdQ[CM_TX]); // R8
  AST_TX_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txStart) |-> $past(busWrEn) && !$past(busWdata[CM_STOP])); // R8
endmodule

// File: rtl/nic_regfile_dp.sv
`timescale 1ns/1ps
module nic_regfile_dp
  import nic_regfile_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int STATION_BYTES = 6,
  parameter int MCAST_BYTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [ADDR_W-1:0] busAddr,
  input  page_e             pageSel,
  input  logic [DATA_W-1:0] cmdQ,
  output logic              rcntZero,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic [DATA_W-1:0] txPage,
  output logic [2*DATA_W-1:0] txLen
);
  localparam int OFF_W = 4;
  localparam int WORD_W = 2*DATA_W;
  localparam logic [DATA_W-1:0] ST_RESET = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] EVENT_BITS = DATA_W'(8'h7F);
  localparam logic [DATA_W-1:0] TX_STATUS_OK = DATA_W'(8'h01);
  localparam logic [OFF_W-1:0] LAST_STATION = OFF_W'(STATION_BYTES);

  logic [DATA_W-1:0] ringStart, ringStop, bound, txStat, status, mask;
  logic [DATA_W-1:0] rxCfg, txCfg, dataCfg, curPage, rnext, lnext;
  logic [WORD_W-1:0] rsar, rcnt, ldma, acnt, txLenQ;
  logic [DATA_W-1:0] station [STATION_BYTES];
  logic [DATA_W-1:0] mcast [MCAST_BYTES];
  logic [DATA_W-1:0] statusNext;

  function automatic logic [WORD_W-1:0] setLo(input logic [WORD_W-1:0] w,
                                              input logic [DATA_W-1:0] b);
    return {w[WORD_W-1:DATA_W], b};
  endfunction
  function automatic logic [WORD_W-1:0] setHi(input logic [WORD_W-1:0] w,
                                              input logic [DATA_W-1:0] b);
    return {b, w[DATA_W-1:0]};
  endfunction

  always_comb begin
    statusNext = status;
    if (strb.clrResetFlag) statusNext[ST_RESET_DONE] = 1'b0;
    if (strb.setRdmaDone)  statusNext[ST_RDMA_DONE]  = 1'b1;
    if (strb.setTxDone)    statusNext[ST_TX_OK]      = 1'b1;
    if (strb.clrStatus)    statusNext = statusNext & ~(busWdata & EVENT_BITS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= ST_RESET;
      mask <= '0;
      ringStart <= '0; ringStop <= '0; bound <= '0; txStat <= '0;
      rxCfg <= '0; txCfg <= '0; dataCfg <= '0; curPage <= '0;
      rnext <= '0; lnext <= '0; txPage <= '0;
      rsar <= '0; rcnt <= '0; ldma <= '0; acnt <= '0; txLenQ <= '0;
    end else begin
      status <= statusNext;
      if (strb.setTxDone) txStat  <= TX_STATUS_OK;
      if (strb.wrMask)    mask    <= busWdata;
      if (strb.wrStart)   ringStart <= busWdata;
      if (strb.wrStop)    ringStop  <= busWdata;
      if (strb.wrBound)   bound   <= busWdata;
      if (strb.wrTxPage)  txPage  <= busWdata;
      if (strb.wrRxCfg)   rxCfg   <= busWdata;
      if (strb.wrTxCfg)   txCfg   <= busWdata;
      if (strb.wrDataCfg) dataCfg <= busWdata;
      if (strb.wrCurPage) curPage <= busWdata;
      if (strb.wrRnext)   rnext   <= busWdata;
      if (strb.wrLnext)   lnext   <= busWdata;
      if (strb.wrTxLenLo) txLenQ  <= setLo(txLenQ, busWdata);
      if (strb.wrTxLenHi) txLenQ  <= setHi(txLenQ, busWdata);
      if (strb.wrRsarLo)  rsar    <= setLo(rsar, busWdata);
      if (strb.wrRsarHi)  rsar    <= setHi(rsar, busWdata);
      if (strb.wrRcntLo)  rcnt    <= setLo(rcnt, busWdata);
      if (strb.wrRcntHi)  rcnt    <= setHi(rcnt, busWdata);
      if (strb.wrLdmaLo)  ldma    <= setLo(ldma, busWdata);
      if (strb.wrLdmaHi)  ldma    <= setHi(ldma, busWdata);
      if (strb.wrAcntLo)  acnt    <= setLo(acnt, busWdata);
      if (strb.wrAcntHi)  acnt    <= setHi(acnt, busWdata);
    end
  end

  for (genvar i = 0; i < STATION_BYTES; i++) begin : g_station
    always_ff @(posedge clk) begin
      if (!rstN) station[i] <= '0;
      else if (strb.wrStation && strb.byteIdx == IDX_W'(i)) station[i] <= busWdata;
    end
  end

  for (genvar i = 0; i < MCAST_BYTES; i++) begin : g_mcast
    always_ff @(posedge clk) begin
      if (!rstN) mcast[i] <= '1;
      else if (strb.wrMcast && strb.byteIdx == IDX_W'(i)) mcast[i] <= busWdata;
    end
  end

  assign rcntZero = (rcnt == '0);
  assign txLen    = txLenQ;
  assign irqOut   = |(status & mask & EVENT_BITS);

  logic [OFF_W-1:0] off;
  logic inWindow;
  assign off      = busAddr[OFF_W-1:0];
  assign inWindow = (busAddr[ADDR_W-1:OFF_W] == '0);

  always_comb begin
    busRdata = '0;
    if (inWindow) begin
      if (off == '0) begin
        busRdata = cmdQ;
      end else begin
        unique case (pageSel)
          PG_ZERO: begin
            unique case (off)
              4'h1: busRdata = ldma[DATA_W-1:0];
              4'h2: busRdata = ldma[WORD_W-1:DATA_W];
              4'h3: busRdata = bound;
              4'h4: busRdata = txStat;
              4'h7: busRdata = status;
              4'h8: busRdata = rsar[DATA_W-1:0];
              4'h9: busRdata = rsar[WORD_W-1:DATA_W];
              default: busRdata = '0;
            endcase
          end
          PG_ONE: begin
            if (off <= LAST_STATION)  busRdata = station[IDX_W'(off - 4'd1)];
            else if (off == 4'h7)     busRdata = curPage;
            else                      busRdata = mcast[off[IDX_W-1:0]];
          end
          PG_TWO: begin
            unique case (off)
              4'h1: busRdata = ringStart;
              4'h2: busRdata = ringStop;
              4'h3: busRdata = rnext;
              4'h4: busRdata = txPage;
              4'h5: busRdata = lnext;
              4'h6: busRdata = acnt[DATA_W-1:0];
              4'h7: busRdata = acnt[WORD_W-1:DATA_W];
              4'hC: busRdata = rxCfg;
              4'hD: busRdata = txCfg;
              4'hE: busRdata = dataCfg;
              4'hF: busRdata = mask;
              default: busRdata = '0;
            endcase
          end
          default: busRdata = '0;
        endcase
      end
    end
  end

  AST_CLEAR_HITS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrStatus |=> (status & $past(busWdata) & EVENT_BITS) == '0); // R4
  AST_CLEAR_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrStatus |=> status[ST_RESET_DONE] == $past(status[ST_RESET_DONE])); // R4
  AST_RESET_FLAG_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrResetFlag |=> !status[ST_RESET_DONE]); // R6
  AST_RDMA_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[ST_RDMA_DONE]) |-> $past(rcntZero)); // R7
endmodule

// File: rtl/nic_regfile.sv
`timescale 1ns/1ps
module nic_regfile
  import nic_regfile_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int STATION_BYTES = 6,
  parameter int MCAST_BYTES = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                irqOut,
  output logic                txStart,
  output logic [DATA_W-1:0]   txPage,
  output logic [2*DATA_W-1:0] txLen
);
  logic [DATA_W-1:0] cmdQ;
  page_e pageSel;
  strobe_t strb;
  logic rcntZero;

  nic_regfile_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATION_BYTES(STATION_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .rcntZero(rcntZero), .cmdQ(cmdQ),
    .pageSel(pageSel), .strb(strb), .txStart(txStart)
  );

  nic_regfile_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .STATION_BYTES(STATION_BYTES), .MCAST_BYTES(MCAST_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .busAddr(busAddr),
    .pageSel(pageSel), .cmdQ(cmdQ), .rcntZero(rcntZero), .busRdata(busRdata),
    .irqOut(irqOut), .txPage(txPage), .txLen(txLen)
  );

  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(busWrEn)); // R5
  AST_READ_NO_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !busWrEn) |=> $stable(irqOut)); // R5
endmodule

// File: tb/nic_regfile_tb.sv
`timescale 1ns/1ps
module nic_regfile_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic irqOut, txStart;
  logic [7:0] txPage;
  logic [15:0] txLen;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  typedef struct { logic [7:0] exp; string tag; logic [4:0] addr; } item_t;
  item_t expQ[$];

  always #10 clk = ~clk;

  nic_regfile u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .txStart(txStart),
    .txPage(txPage), .txLen(txLen)
  );

  // monitor: compares read data against the scoreboard
  always @(negedge clk) begin
    if (busRdEn && expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      nChecks++;
      if (busRdata !== it.exp) begin
        nFails++;
        $display("FAIL %s addr 0x%02h: actual 0x%02h expected 0x%02h",
                 it.tag, it.addr, busRdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(posedge clk); #2;
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #2;
    it.exp = e; it.tag = tag; it.addr = a;
    expQ.push_back(it);
    busAddr = a; busRdEn = 1'b1;
    @(posedge clk); #2;
    busRdEn = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R1 reset values
    rd(5'h00, 8'h22, "R1 cmd");
    rd(5'h07, 8'h80, "R1 status");
    chk("R5 irq idle", irqOut, 0);

    // R2/R9 page 1, stop held so status bit 7 stays
    wr(5'h00, 8'h41);
    rd(5'h00, 8'h41, "R2 cmd page1");
    rd(5'h08, 8'hFF, "R1 mcast0");
    rd(5'h0F, 8'hFF, "R1 mcast7");
    for (int i = 1; i <= 6; i++) wr(5'(i), 8'(8'h10 + i));
    wr(5'h07, 8'h4C);
    wr(5'h09, 8'h5A);
    for (int i = 1; i <= 6; i++) rd(5'(i), 8'(8'h10 + i), "R9 station");
    rd(5'h07, 8'h4C, "R9 curpage");
    rd(5'h09, 8'h5A, "R9 mcast1");
    rd(5'h0A, 8'hFF, "R9 mcast2 untouched");

    // R2/R11 page 3 decodes nothing
    wr(5'h00, 8'hC1);
    rd(5'h00, 8'hC1, "R2 cmd page3");
    wr(5'h07, 8'h99);
    rd(5'h07, 8'h00, "R11 page3 read");
    rd(5'h03, 8'h00, "R11 page3 read");
    wr(5'h00, 8'h41);
    rd(5'h07, 8'h4C, "R11 page3 write ignored");

    // R3/R12 page 0 asymmetry
    wr(5'h00, 8'h01);
    rd(5'h07, 8'h80, "R6 stop keeps flag");
    wr(5'h01, 8'h46); wr(5'h02, 8'h80); wr(5'h04, 8'h40);
    wr(5'h0C, 8'h0E); wr(5'h0D, 8'h02); wr(5'h0E, 8'h48);
    rd(5'h04, 8'h00, "R3 tx status read");
    rd(5'h01, 8'h00, "R3 ldma low read");
    wr(5'h00, 8'h81);
    rd(5'h01, 8'h46, "R3 start page");
    rd(5'h02, 8'h80, "R12 stop page");
    rd(5'h04, 8'h40, "R3 tx page");
    rd(5'h0C, 8'h0E, "R12 rx cfg");
    rd(5'h0D, 8'h02, "R12 tx cfg");
    rd(5'h0E, 8'h48, "R12 data cfg");
    rd(5'h0F, 8'h00, "R5 mask readback");
    wr(5'h01, 8'h33); wr(5'h02, 8'h77);
    rd(5'h01, 8'h46, "R3 start page kept");
    wr(5'h00, 8'h01);
    rd(5'h01, 8'h33, "R3 ldma low");
    rd(5'h02, 8'h77, "R3 ldma high");

    // R10 16-bit pairs
    wr(5'h08, 8'h34); wr(5'h09, 8'h12);
    rd(5'h08, 8'h34, "R10 rsar low");
    rd(5'h09, 8'h12, "R10 rsar high");
    wr(5'h05, 8'hEA); wr(5'h06, 8'h05);
    chk("R10 txLen", txLen, 16'h05EA);
    chk("R10 txPage", txPage, 8'h40);

    // R6 start clears reset flag
    wr(5'h00, 8'h02);
    rd(5'h07, 8'h00, "R6 flag cleared");

    // R7 remote request vs count
    wr(5'h0A, 8'h00); wr(5'h0B, 8'h01);
    wr(5'h00, 8'h0A);
    rd(5'h07, 8'h00, "R7 nonzero count");
    wr(5'h0B, 8'h00);
    wr(5'h00, 8'h0A);
    rd(5'h07, 8'h40, "R7 zero count");
    wr(5'h07, 8'h40);
    rd(5'h07, 8'h00, "R4 clear bit6");
    wr(5'h0A, 8'h01);
    wr(5'h00, 8'h12);
    rd(5'h07, 8'h00, "R7 low byte count");

    // R8 transmit
    wr(5'h0F, 8'h02);
    chk("R5 irq masked idle", irqOut, 0);
    wr(5'h00, 8'h06);
    #3 chk("R8 txStart pulse", txStart, 1);
    chk("R5 irq on tx", irqOut, 1);
    @(posedge clk); #2 chk("R8 txStart one cycle", txStart, 0);
    rd(5'h00, 8'h02, "R8 cmd bit2 cleared");
    rd(5'h04, 8'h01, "R8 tx status");
    rd(5'h07, 8'h02, "R8 status bit1");

    // R4 write-one-to-clear
    wr(5'h07, 8'h80);
    rd(5'h07, 8'h02, "R4 bit7 write no effect");
    chk("R5 irq held", irqOut, 1);
    wr(5'h07, 8'h02);
    rd(5'h07, 8'h00, "R4 bit1 cleared");
    chk("R5 irq drop", irqOut, 0);

    // R8 stop held: no transmit
    wr(5'h00, 8'h05);
    #3 chk("R8 no pulse when stopped", txStart, 0);
    @(posedge clk); #2 chk("R8 no pulse later", txStart, 0);
    rd(5'h00, 8'h05, "R8 cmd stored as written");
    rd(5'h07, 8'h00, "R8 status untouched");

    // R5 mask gating
    wr(5'h0A, 8'h00); wr(5'h0B, 8'h00);
    wr(5'h00, 8'h0A);
    chk("R5 masked event", irqOut, 0);
    wr(5'h0F, 8'h40);
    chk("R5 unmasked event", irqOut, 1);
    wr(5'h0F, 8'h00);
    chk("R5 remasked", irqOut, 0);

    // R11 upper port range
    wr(5'h03, 8'h50);
    wr(5'h13, 8'hAA);
    rd(5'h03, 8'h50, "R11 upper write ignored");
    rd(5'h10, 8'h00, "R11 upper read");
    rd(5'h05, 8'h00, "R11 page0 gap read");

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule